// File: doc/BRIEF.md
# Pulse Midpoint Beat Timestamper

This block takes the digital heartbeat pulse from a threshold comparator and turns each pulse into a precise beat time. The pulse is only trusted on sample instants, which are marked by a one-cycle `sample_tick` strobe (about 2 kHz in the intended use). A free-running sample counter timestamps the sampled rising and falling edges of each pulse.

The beat time is the midpoint of the two edges, not the rising edge. When the amplified peak is clipped, the pulse widens on both sides of the true peak, so the leading edge arrives early but the centre stays put. The midpoint is kept in half-sample units: the least significant bit of every timestamp and interval is worth half a sample period, so odd pulse widths lose nothing. Each accepted beat gives one record on a valid/ready output. The record holds the midpoint, the interval since the previous accepted midpoint, and a flag that says whether that interval has meaning.

Back-pressure rules: a record stays on `out_valid`/`out_mid`/`out_ivl`/`out_ivl_ok` without change until a cycle where `out_ready` is high. If a further beat completes while a record is still waiting, that newer record is not presented. It still becomes the reference point for the next interval. When `out_ready` is held high, `out_valid` lasts exactly one cycle per beat.

Top module: `beat_midpoint_stamper`

## Requirements
- R1: After reset, `out_valid` and `err_stuck` are 0 and the sample counter starts at 0, so the first `sample_tick` is sample index 0.
- R2: `out_mid` equals rise index plus fall index, in half-sample units. Bits [CNT_W:1] are whole samples and bit 0 is a half sample. The rise index is the first sample that reads `beat_in` high after a low sample (or after reset). The fall index is the first sample that then reads it low.
- R3: `beat_in` is looked at only in cycles where `sample_tick` is 1. A high level that appears and goes away between two ticks has no effect.
- R4: `out_ivl` is the current midpoint minus the previous accepted midpoint, modulo 2^(CNT_W+1), in half-sample units.
- R5: The first accepted beat after reset has `out_ivl_ok` = 0. Every later accepted beat has `out_ivl_ok` = 1.
- R6: A pulse is discarded if it still reads high at the sample MAX_W samples after its rise. That sample causes a one-cycle `err_stuck` pulse in the next cycle. No record is produced, and the discarded pulse is not used as a reference.
- R7: A pulse whose fall index is exactly MAX_W samples after its rise is accepted as a normal beat.
- R8: Edge indices wrap modulo 2^CNT_W. A pulse that rises before the wrap and falls after it gets the correct midpoint modulo 2^(CNT_W+1).
- R9: While `out_valid` is 1 and `out_ready` is 0, the record holds steady. A beat completing in that time is not presented but still becomes the interval reference.
- R10: A record appears in the cycle right after the tick that sampled the falling edge. With `out_ready` high, `out_valid` stays 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | One-cycle strobe that marks a sample instant |
| beat_in | input | 1 | Comparator heartbeat pulse, synchronous to clk |
| out_valid | output | 1 | Record is present |
| out_ready | input | 1 | Consumer accepts the record |
| out_mid | output | CNT_W+1 | Midpoint timestamp, LSB = half sample |
| out_ivl | output | CNT_W+1 | Interval to the previous accepted midpoint, LSB = half sample |
| out_ivl_ok | output | 1 | Interval is meaningful (not the first beat) |
| err_stuck | output | 1 | One-cycle flag for a pulse discarded as too wide |

## Verification
The bench uses pulses of odd and even width to tell a true midpoint apart from a truncated one or from a leading-edge time. It tests single-cycle glitches placed between ticks, to confirm that the block samples only on ticks. It tests pulses of exactly MAX_W and MAX_W+5 samples, which pins down the boundary between an accepted beat and a stuck one. It holds back `out_ready` across several beats, which shows the difference between holding, dropping and still-referencing a record. It places a pulse across the counter wrap, which exposes any non-modular arithmetic.

// File: rtl/bms_pkg.sv
package bms_pkg;
  typedef enum logic [1:0] {
    TRK_LOW   = 2'd0,
    TRK_HIGH  = 2'd1,
    TRK_STUCK = 2'd2
  } trk_state_e;
endpackage

// File: rtl/bms_sample_clock.sv
module bms_sample_clock #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] idx
);
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (tick) idx_q <= idx_q + 1'b1;
  end

  assign idx = idx_q;

  // R3: the index only moves on sample instants
  assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(idx_q));
endmodule

// File: rtl/bms_pulse_tracker.sv
module bms_pulse_tracker
  import bms_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int MAX_W = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             beat,
  input  logic [CNT_W-1:0] idx,
  output logic             fall_evt,
  output logic             stuck_evt,
  output logic [CNT_W-1:0] rise_idx
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_W);

  trk_state_e       st_q, st_d;
  logic [CNT_W-1:0] rise_q;
  logic [CNT_W-1:0] age;

  assign age = idx - rise_q;

  always_comb begin
    st_d      = st_q;
    fall_evt  = 1'b0;
    stuck_evt = 1'b0;
    if (tick) begin
      unique case (st_q)
        TRK_LOW: if (beat) st_d = TRK_HIGH;
        TRK_HIGH: begin
          if (!beat) begin
            st_d     = TRK_LOW;
            fall_evt = 1'b1;
          end else if (age == MAX_V) begin
            st_d      = TRK_STUCK;
            stuck_evt = 1'b1;
          end
        end
        TRK_STUCK: if (!beat) st_d = TRK_LOW;
        default: st_d = TRK_LOW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TRK_LOW;
      rise_q <= '0;
    end else begin
      st_q <= st_d;
      if (tick && st_q == TRK_LOW && beat) rise_q <= idx;
    end
  end

  assign rise_idx = rise_q;

  // R7: an accepted pulse is never wider than the limit
  assert_width_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> (age <= MAX_V));
endmodule

// File: rtl/bms_stamp_math.sv
module bms_stamp_math #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_evt,
  input  logic [CNT_W-1:0] rise_idx,
  input  logic [CNT_W-1:0] fall_idx,
  output logic [CNT_W:0]   rec_mid,
  output logic [CNT_W:0]   rec_ivl,
  output logic             rec_ok
);
  logic [CNT_W-1:0] width;
  logic [CNT_W:0]   prev_q;
  logic             seen_q;

  assign width   = fall_idx - rise_idx;
  assign rec_mid = {rise_idx, 1'b0} + {1'b0, width};
  assign rec_ivl = rec_mid - prev_q;
  assign rec_ok  = seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (fall_evt) begin
      prev_q <= rec_mid;
      seen_q <= 1'b1;
    end
  end

  // R5: once a reference exists it is never lost
  assert_seen_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> seen_q);
endmodule

// File: rtl/bms_record_slot.sv
module bms_record_slot #(
  parameter int DW = 51
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_stb,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          valid_q;
  logic [DW-1:0] data_q;
  logic          load;

  assign load = in_stb && (!valid_q || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (load) begin
        valid_q <= 1'b1;
        data_q  <= in_data;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  // R9: a waiting record is held steady
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !out_ready |=> valid_q && $stable(data_q));
endmodule

// File: rtl/beat_midpoint_stamper.sv
module beat_midpoint_stamper #(
  parameter int CNT_W = 24,
  parameter int MAX_W = 400
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_tick,
  input  logic           beat_in,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [CNT_W:0] out_mid,
  output logic [CNT_W:0] out_ivl,
  output logic           out_ivl_ok,
  output logic           err_stuck
);
  localparam int SW = CNT_W + 1;
  localparam int DW = 2 * SW + 1;

  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] rise_idx;
  logic             fall_evt;
  logic             stuck_evt;
  logic [SW-1:0]    rec_mid;
  logic [SW-1:0]    rec_ivl;
  logic             rec_ok;
  logic [DW-1:0]    slot_data;
  logic             err_q;

  bms_sample_clock #(.CNT_W(CNT_W)) u_clock (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .idx(idx)
  );

  bms_pulse_tracker #(.CNT_W(CNT_W), .MAX_W(MAX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .beat(beat_in), .idx(idx),
    .fall_evt(fall_evt), .stuck_evt(stuck_evt), .rise_idx(rise_idx)
  );

  bms_stamp_math #(.CNT_W(CNT_W)) u_math (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .rise_idx(rise_idx),
    .fall_idx(idx), .rec_mid(rec_mid), .rec_ivl(rec_ivl), .rec_ok(rec_ok)
  );

  bms_record_slot #(.DW(DW)) u_slot (
    .clk(clk), .rst_n(rst_n), .in_stb(fall_evt),
    .in_data({rec_ok, rec_ivl, rec_mid}),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(slot_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= stuck_evt;
  end

  assign out_mid    = slot_data[SW-1:0];
  assign out_ivl    = slot_data[2*SW-1:SW];
  assign out_ivl_ok = slot_data[DW-1];
  assign err_stuck  = err_q;

  // R10: a record only appears right after a sample instant
  assert_record_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(sample_tick));

  // R6: the stuck flag is a single-cycle pulse
  assert_stuck_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_stuck |=> !err_stuck);
endmodule

// File: tb/test_beat_midpoint_stamper.sv
module test_beat_midpoint_stamper;
  localparam int CW = 10;
  localparam int MW = 40;
  localparam int M  = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_tick = 1'b0;
  logic          beat_in = 1'b0;
  logic          out_ready = 1'b1;
  logic          out_valid;
  logic [CW:0]   out_mid;
  logic [CW:0]   out_ivl;
  logic          out_ivl_ok;
  logic          err_stuck;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  string req = "R1";

  // reference model state
  int  smp = 0, rise_t = 0, prev_mid = 0;
  bit  lvl = 0, tracking = 0, have_prev = 0;
  bit  e_valid = 0, e_ok = 0, e_err = 0;
  int  e_mid = 0, e_ivl = 0;

  always #5 clk = ~clk;

  beat_midpoint_stamper #(.CNT_W(CW), .MAX_W(MW)) i_beat_midpoint_stamper (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .beat_in(beat_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_mid(out_mid),
    .out_ivl(out_ivl), .out_ivl_ok(out_ivl_ok), .err_stuck(err_stuck)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      smp = 0; rise_t = 0; prev_mid = 0; lvl = 0; tracking = 0;
      have_prev = 0; e_valid = 0; e_ok = 0; e_err = 0; e_mid = 0; e_ivl = 0;
    end else begin
      e_err = 0;
      if (e_valid && out_ready) e_valid = 0;
      if (sample_tick) begin
        if (beat_in && !lvl) begin
          rise_t = smp; tracking = 1;
        end else if (beat_in && lvl && tracking && ((smp - rise_t + M) % M) == MW) begin
          tracking = 0; e_err = 1;
        end else if (!beat_in && lvl && tracking) begin
          int w, mid;
          w   = (smp - rise_t + M) % M;
          mid = (2 * rise_t + w) % (2 * M);
          if (!e_valid) begin
            e_valid = 1; e_mid = mid;
            e_ivl = (mid - prev_mid + 2 * M) % (2 * M);
            e_ok = have_prev;
          end
          have_prev = 1; prev_mid = mid; tracking = 0;
        end
        lvl = beat_in;
        smp = (smp + 1) % M;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n || cycles > 2) begin
      vectors++;
      if (out_valid !== e_valid) begin
        misses++;
        $display("FAIL %s out_valid: actual %0b expected %0b", req, out_valid, e_valid);
      end
      if (err_stuck !== e_err) begin
        misses++;
        $display("FAIL %s err_stuck: actual %0b expected %0b", req, err_stuck, e_err);
      end
      if (e_valid && out_valid) begin
        if (int'(out_mid) != e_mid || int'(out_ivl) != e_ivl || out_ivl_ok !== e_ok) begin
          misses++;
          $display("FAIL %s record: actual mid %0d ivl %0d ok %0b expected mid %0d ivl %0d ok %0b",
                   req, out_mid, out_ivl, out_ivl_ok, e_mid, e_ivl, e_ok);
        end
      end
    end
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic cyc(input logic b, input logic t);
    beat_in = b; sample_tick = t;
    @(negedge clk);
  endtask

  task automatic samp(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(b, 1'b1);
      cyc(b, 1'b0);
    end
  endtask

  task automatic pulse(input int lo, input int hi);
    samp(1'b0, lo);
    samp(1'b1, hi);
    samp(1'b0, 2);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state observed on the ports while held
    req = "R1";
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0);

    // R2 R5 R10: odd and even widths, first beat has no valid interval
    req = "R2_R5_R10";
    pulse(5, 7);
    pulse(20, 8);
    req = "R4";
    pulse(13, 3);
    pulse(31, 1);

    // R3: glitches between ticks do nothing
    req = "R3";
    for (int k = 0; k < 6; k++) begin
      cyc(1'b0, 1'b1);
      cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b0);
    end
    pulse(4, 5);

    // R6: stuck pulse discarded, R7: width exactly at limit accepted
    req = "R6";
    pulse(10, MW + 5);
    pulse(9, 6);
    req = "R7";
    pulse(10, MW);
    pulse(12, MW - 1);

    // R9: back-pressure hold, drop and still reference
    req = "R9";
    out_ready = 1'b0;
    pulse(6, 4);
    pulse(7, 9);
    pulse(8, 2);
    repeat (5) cyc(1'b0, 1'b0);
    out_ready = 1'b1;
    cyc(1'b0, 1'b0);
    pulse(5, 3);
    out_ready = 1'b0;
    pulse(4, 5);
    cyc(1'b0, 1'b0);
    out_ready = 1'b1;
    cyc(1'b0, 1'b0);

    // R8: pulse straddling the counter wrap
    req = "R8";
    while (smp != M - 3) samp(1'b0, 1);
    samp(1'b1, 6);
    samp(1'b0, 3);
    pulse(25, 11);

    req = "R10";
    repeat (4) pulse(15, 2);
    repeat (4) cyc(1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule